// File: doc/BRIEF.md
# USB Node Main Control Register

This block is the 8-bit main control register of a full-speed USB device node. Firmware reaches it through a simple register bus with an address, write and read strobes and byte-wide data. The register controls the node's power-up and attach sequence. It enables the internal 3.3 V regulator. It releases the bus from a forced SE0 state once firmware is ready to be seen by the upstream hub. It selects how the interrupt pin is driven.

Writing 1 to the software-reset bit starts a reset of the whole device. The block sends a pulse of fixed length to the other registers, and that bit reads back as 1 until the pulse ends. A software reset clears the attach bit, the interrupt mode and the status flag. The regulator enable is cleared only by the hardware reset input. This lets a reset from firmware run without dropping the node's supply.

The block also has an early-attach status flag. It is set when firmware attaches the node before the regulator has been on for a set number of cycles, which is 1 ms at the default setting.

Top module: `usb_node_ctl_reg`

## Requirements
- R1: While or after the hardware reset is asserted, the register reads 0x00. reg_en is 0, force_se0 is 1, irq_mode is 00, sw_rst_pulse is 0 and early_attach is 0.
- R2: A write to REG_ADDR with data bit 0 set raises sw_rst_pulse in the next cycle. The pulse lasts exactly SRST_CYCLES cycles (4 by default). Bit 0 reads 1 during the pulse and 0 after it.
- R3: A software reset clears the attach bit (bit 3), the mode field (bits 7:6) and early_attach. It leaves the regulator bit (bit 2) and reg_en unchanged. A write that starts a software reset changes no other field.
- R4: Every write that falls within the sw_rst_pulse window is ignored, including one that sets bit 0 again. Reset values take priority over written values.
- R5: Bit 2 is the regulator enable. It drives reg_en from the cycle after the write.
- R6: Bit 3 is the attach bit. force_se0 is 1 exactly while this bit is 0.
- R7: Bits 7:6 read back as written. irq_mode encodes the field as 00 for active-low push-pull, 01 for active-high push-pull and 10 for active-low open-drain. The reserved code 11 is read back as 11 but gives an irq_mode of 00.
- R8: Bits 1, 4 and 5 always read as 0, and the values written to them have no effect.
- R9: Writes to any address other than REG_ADDR change nothing. bus_rdata is 0x00 when bus_rd is low or the address does not match.
- R10: early_attach is set by a write that raises the attach bit while the new regulator bit is 1, if that write lands fewer than ATTACH_DELAY_CYCLES clock edges after the write that set the regulator bit. A write that sets both bits together counts as 0 edges. The flag stays 1 until a reset. It is never set if the regulator bit is 0, or if the write lands ATTACH_DELAY_CYCLES edges or later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| hw_rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| sw_rst_pulse | output | 1 | Software reset toward the other registers |
| reg_en | output | 1 | Internal regulator enable |
| force_se0 | output | 1 | Transceiver drives SE0 while high |
| irq_mode | output | 2 | Effective interrupt output mode |
| early_attach | output | 1 | Attach requested before the regulator settled |

## Verification
A register write and an active software reset can fall in the same cycle. The bench provokes this by writing to the attach bit, the mode bit and the reset bit while the pulse is running. It judges the result by reading back after the pulse: the write must have been dropped and the pulse must not have been stretched. The attach write and the settle timer also meet in one cycle. This is probed with writes placed exactly one edge before and exactly on the delay boundary, and with a write that sets the regulator and attach bits together.

// File: rtl/usb_node_ctl_pkg.sv
package usb_node_ctl_pkg;

    localparam int unsigned SRST_BIT  = 0;
    localparam int unsigned VGE_BIT   = 2;
    localparam int unsigned NAT_BIT   = 3;
    localparam int unsigned MODE_LSB  = 6;
    localparam int unsigned MODE_MSB  = 7;

    typedef enum logic [1:0] {
        IRQ_LOW_PUSHPULL  = 2'b00,
        IRQ_HIGH_PUSHPULL = 2'b01,
        IRQ_LOW_OPENDRAIN = 2'b10,
        IRQ_RESERVED      = 2'b11
    } irq_mode_e;

    typedef struct packed {
        logic      vge;
        logic      nat;
        logic [1:0] mode;
    } ctl_fields_t;

    localparam ctl_fields_t CTL_RESET = '{vge: 1'b0, nat: 1'b0, mode: 2'b00};

    function automatic logic [1:0] effective_mode(input logic [1:0] raw);
        logic [1:0] res;
        case (irq_mode_e'(raw))
            IRQ_HIGH_PUSHPULL: res = IRQ_HIGH_PUSHPULL;
            IRQ_LOW_OPENDRAIN: res = IRQ_LOW_OPENDRAIN;
            default:           res = IRQ_LOW_PUSHPULL;
        endcase
        return res;
    endfunction

    function automatic logic [7:0] pack_readback(input ctl_fields_t f, input logic busy);
        logic [7:0] v;
        v = 8'h00;
        v[SRST_BIT] = busy;
        v[VGE_BIT]  = f.vge;
        v[NAT_BIT]  = f.nat;
        v[MODE_MSB:MODE_LSB] = f.mode;
        return v;
    endfunction

endpackage

// File: rtl/unc_srst_seq.sv
module unc_srst_seq #(
    parameter int unsigned SRST_CYCLES = 4
) (
    input  logic clk,
    input  logic hw_rst_n,
    input  logic start,
    output logic active
);

    localparam int unsigned CNT_W = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(SRST_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] left;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (seq_q.busy) begin
            if (seq_q.left == '0) begin
                seq_d.busy = 1'b0;
            end else begin
                seq_d.left = seq_q.left - 1'b1;
            end
        end else if (start) begin
            seq_d.busy = 1'b1;
            seq_d.left = LOAD;
        end
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign active = seq_q.busy;

    // R2
    srst_start_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (start && !seq_q.busy) |=> seq_q.busy);

    // R2
    srst_end_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (seq_q.busy && seq_q.left == '0) |=> !seq_q.busy);

endmodule

// File: rtl/unc_attach_guard.sv
module unc_attach_guard #(
    parameter int unsigned DELAY_CYCLES = 50000,
    parameter bit          FLAG_EN      = 1'b1
) (
    input  logic clk,
    input  logic hw_rst_n,
    input  logic vge_now,
    input  logic vge_next,
    input  logic nat_rise,
    input  logic clear,
    output logic early
);

    localparam int unsigned CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'((DELAY_CYCLES > 0) ? DELAY_CYCLES - 1 : 0);

    generate
        if (FLAG_EN) begin : g_guard
            typedef struct packed {
                logic [CNT_W-1:0] age;
                logic             flag;
            } grd_t;

            grd_t grd_d, grd_q;
            logic too_soon;

            always_comb begin
                grd_d = grd_q;
                if (!vge_now) begin
                    grd_d.age = '0;
                end else if (grd_q.age != LIMIT) begin
                    grd_d.age = grd_q.age + 1'b1;
                end
                too_soon = !vge_now || (grd_q.age < LIMIT);
                if (clear) begin
                    grd_d.flag = 1'b0;
                end else if (nat_rise && vge_next && too_soon) begin
                    grd_d.flag = 1'b1;
                end
            end

            always_ff @(posedge clk or negedge hw_rst_n) begin
                if (!hw_rst_n) begin
                    grd_q <= '0;
                end else begin
                    grd_q <= grd_d;
                end
            end

            assign early = grd_q.flag;

            // R10
            flag_needs_vge_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
                (!grd_q.flag && !vge_next) |=> !grd_q.flag);
        end else begin : g_noguard
            logic unused_guard_in;
            assign unused_guard_in = ^{vge_now, vge_next, nat_rise, clear};
            assign early = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/usb_node_ctl_reg.sv
module usb_node_ctl_reg
    import usb_node_ctl_pkg::*;
#(
    parameter int unsigned        ADDR_W              = 4,
    parameter logic [ADDR_W-1:0]  REG_ADDR            = '0,
    parameter int unsigned        SRST_CYCLES         = 4,
    parameter int unsigned        ATTACH_DELAY_CYCLES = 50000,
    parameter bit                 EARLY_FLAG_EN       = 1'b1
) (
    input  logic              clk,
    input  logic              hw_rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              sw_rst_pulse,
    output logic              reg_en,
    output logic              force_se0,
    output logic [1:0]        irq_mode,
    output logic              early_attach
);

    ctl_fields_t fld_d, fld_q;
    logic        addr_hit;
    logic        wr_ok;
    logic        srst_start;
    logic        nat_rise;
    logic        rst_busy;
    logic        unused_rsvd_wdata;

    assign unused_rsvd_wdata = ^{bus_wdata[5:4], bus_wdata[1]};

    always_comb begin
        addr_hit   = (bus_addr == REG_ADDR);
        wr_ok      = bus_wr && addr_hit && !rst_busy;
        srst_start = wr_ok && bus_wdata[SRST_BIT];
        nat_rise   = 1'b0;
        fld_d      = fld_q;
        if (srst_start) begin
            fld_d.nat  = CTL_RESET.nat;
            fld_d.mode = CTL_RESET.mode;
        end else if (wr_ok) begin
            fld_d.vge  = bus_wdata[VGE_BIT];
            fld_d.nat  = bus_wdata[NAT_BIT];
            fld_d.mode = bus_wdata[MODE_MSB:MODE_LSB];
            nat_rise   = bus_wdata[NAT_BIT] && !fld_q.nat;
        end
    end

    always_ff @(posedge clk or negedge hw_rst_n) begin
        if (!hw_rst_n) begin
            fld_q <= CTL_RESET;
        end else begin
            fld_q <= fld_d;
        end
    end

    unc_srst_seq #(
        .SRST_CYCLES(SRST_CYCLES)
    ) u_srst (
        .clk      (clk),
        .hw_rst_n (hw_rst_n),
        .start    (srst_start),
        .active   (rst_busy)
    );

    unc_attach_guard #(
        .DELAY_CYCLES(ATTACH_DELAY_CYCLES),
        .FLAG_EN     (EARLY_FLAG_EN)
    ) u_guard (
        .clk      (clk),
        .hw_rst_n (hw_rst_n),
        .vge_now  (fld_q.vge),
        .vge_next (fld_d.vge),
        .nat_rise (nat_rise),
        .clear    (srst_start),
        .early    (early_attach)
    );

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd && addr_hit) begin
            bus_rdata = pack_readback(fld_q, rst_busy);
        end
    end

    assign sw_rst_pulse = rst_busy;
    assign reg_en       = fld_q.vge;
    assign force_se0    = !fld_q.nat;
    assign irq_mode     = effective_mode(fld_q.mode);

    // R3
    vge_keep_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        sw_rst_pulse |=> (reg_en == $past(reg_en)));

    // R3
    reset_clears_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        sw_rst_pulse |-> (force_se0 && irq_mode == 2'b00 && !early_attach));

    // R4
    busy_write_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (sw_rst_pulse && bus_wr) |=> (force_se0 && irq_mode == 2'b00));

    // R9
    stray_write_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        (bus_wr && bus_addr != REG_ADDR && !sw_rst_pulse) |=>
        ($stable(reg_en) && $stable(force_se0) && $stable(irq_mode) && !$rose(sw_rst_pulse)));

    // R10
    early_flag_chk: assert property (@(posedge clk) disable iff (!hw_rst_n)
        $rose(early_attach) |-> (reg_en && !force_se0));

endmodule

// File: tb/usb_node_ctl_reg_test.sv
module usb_node_ctl_reg_test;

    localparam int unsigned AW    = 4;
    localparam logic [AW-1:0] RA  = 4'h5;
    localparam int unsigned DLY   = 20;

    typedef struct packed {
        logic [7:0] wd;
        logic [7:0] rb;
        logic       en;
        logic       se0;
        logic [1:0] irq;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{wd: 8'h04, rb: 8'h04, en: 1'b1, se0: 1'b1, irq: 2'b00},
        '{wd: 8'h0C, rb: 8'h0C, en: 1'b1, se0: 1'b0, irq: 2'b00},
        '{wd: 8'h4C, rb: 8'h4C, en: 1'b1, se0: 1'b0, irq: 2'b01},
        '{wd: 8'h8C, rb: 8'h8C, en: 1'b1, se0: 1'b0, irq: 2'b10},
        '{wd: 8'hCC, rb: 8'hCC, en: 1'b1, se0: 1'b0, irq: 2'b00},
        '{wd: 8'hFE, rb: 8'hCC, en: 1'b1, se0: 1'b0, irq: 2'b00},
        '{wd: 8'h40, rb: 8'h40, en: 1'b0, se0: 1'b1, irq: 2'b01},
        '{wd: 8'h00, rb: 8'h00, en: 1'b0, se0: 1'b1, irq: 2'b00}
    };

    logic          clk = 1'b0;
    logic          hw_rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          sw_rst_pulse, reg_en, force_se0, early_attach;
    logic [1:0]    irq_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    usb_node_ctl_reg #(
        .ADDR_W(AW), .REG_ADDR(RA), .SRST_CYCLES(4),
        .ATTACH_DELAY_CYCLES(DLY), .EARLY_FLAG_EN(1'b1)
    ) uut (
        .clk(clk), .hw_rst_n(hw_rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sw_rst_pulse(sw_rst_pulse), .reg_en(reg_en), .force_se0(force_se0),
        .irq_mode(irq_mode), .early_attach(early_attach)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_at(input logic [AW-1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_at(RA, d);
    endtask

    task automatic rd_at(input logic [AW-1:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #2;
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic hw_reset();
        hw_rst_n = 1'b0;
        idle(2);
        hw_rst_n = 1'b1;
        idle(1);
    endtask

    initial begin
        logic [7:0] v;
        @(negedge clk);
        hw_rst_n = 1'b0;
        idle(2);
        // R1 during reset
        rd_at(RA, v);
        check("R1 rdata in reset", v, 8'h00);
        check("R1 force_se0 in reset", {7'd0, force_se0}, 8'h01);
        hw_rst_n = 1'b1;
        idle(1);
        rd_at(RA, v);
        check("R1 rdata", v, 8'h00);
        check("R1 outputs", {2'b0, sw_rst_pulse, reg_en, force_se0, irq_mode, early_attach}, 8'b0000_1000);

        // vector table: R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            wr(VECS[i].wd);
            rd_at(RA, v);
            check($sformatf("R7 R8 readback vec %0d", i), v, VECS[i].rb);
            check($sformatf("R5 reg_en vec %0d", i), {7'd0, reg_en}, {7'd0, VECS[i].en});
            check($sformatf("R6 force_se0 vec %0d", i), {7'd0, force_se0}, {7'd0, VECS[i].se0});
            check($sformatf("R7 irq_mode vec %0d", i), {6'd0, irq_mode}, {6'd0, VECS[i].irq});
        end

        // R9 other address and idle read
        wr(8'h4C);
        wr_at(4'h3, 8'h00);
        wr_at(4'h3, 8'h01);
        check("R9 no pulse from stray write", {7'd0, sw_rst_pulse}, 8'h00);
        rd_at(4'h3, v);
        check("R9 stray read", v, 8'h00);
        rd_at(RA, v);
        check("R9 field kept", v, 8'h4C);
        bus_addr = RA; #2;
        check("R9 rdata without rd", bus_rdata, 8'h00);

        // R2 R3 software reset
        hw_reset();
        wr(8'h04);
        idle(DLY + 2);
        wr(8'h4C);
        wr(8'h01);
        check("R2 pulse first cycle", {7'd0, sw_rst_pulse}, 8'h01);
        rd_at(RA, v);
        check("R2 R3 readback during reset", v, 8'h05);
        // R4 writes during the window
        wr(8'h8C);
        wr(8'h0D);
        idle(1);
        check("R2 pulse fourth cycle", {7'd0, sw_rst_pulse}, 8'h01);
        idle(1);
        check("R2 pulse ended", {7'd0, sw_rst_pulse}, 8'h00);
        rd_at(RA, v);
        check("R2 R4 readback after reset", v, 8'h04);
        check("R3 reg_en kept", {7'd0, reg_en}, 8'h01);
        check("R3 force_se0 after reset", {7'd0, force_se0}, 8'h01);
        idle(1);
        check("R4 no extension", {7'd0, sw_rst_pulse}, 8'h00);

        // R1 hardware reset clears regulator
        hw_reset();
        check("R1 reg_en after hw reset", {7'd0, reg_en}, 8'h00);

        // R10 early attach cases
        wr(8'h04); idle(9); wr(8'h0C);
        check("R10 early at 10", {7'd0, early_attach}, 8'h01);
        wr(8'h4D);
        idle(4);
        check("R3 flag cleared by sw reset", {7'd0, early_attach}, 8'h00);

        hw_reset();
        wr(8'h04); idle(DLY - 2); wr(8'h0C);
        check("R10 early one edge before limit", {7'd0, early_attach}, 8'h01);

        hw_reset();
        wr(8'h04); idle(DLY - 1); wr(8'h0C);
        check("R10 not early at limit", {7'd0, early_attach}, 8'h00);

        hw_reset();
        wr(8'h0C);
        check("R10 same-write attach", {7'd0, early_attach}, 8'h01);

        hw_reset();
        wr(8'h08);
        check("R10 external supply", {7'd0, early_attach}, 8'h00);
        check("R6 attach without regulator", {7'd0, force_se0}, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule